// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the device-side serial port of a small NOR flash. It watches the four host pins (serial clock, active-low select, data in and active-low pause) through synchronizers clocked by a faster system clock, assembles opcode, address and filler bytes, and serves the read-type commands itself. Array reads fetch bytes through a single-cycle synchronous read port. Status reads return a byte supplied by the status logic. The two identification reads return fixed codes. The serial output comes with a separate enable so that the pad can float.

Commands that change stored state (write-enable latch set or clear, the three erase sizes, page program and status write) are only checked for framing and then handed on. A one-cycle strobe carries the opcode and the 18-bit address at the moment select rises, and each payload byte of a program or status write is passed on with its own strobe. The block also holds the deep-sleep state and implements the pause pin.

Top module: `spi_flash_frontend`

## Requirements
- R1: The clock polarity is taken from the serial clock level when select falls: low means mode 0, high means mode 3. Both give identical results with no configuration.
- R2: Input bits are taken MSB first on rising serial clock edges, and output bits change on falling edges. `so_oe_o` is low whenever no data is being driven, and in particular after select rises.
- R3: Opcode 03h followed by three address bytes streams array bytes, starting at that address, on the following falling edges.
- R4: Opcode 0Bh behaves like 03h, except that one filler byte follows the address before data begins.
- R5: During a read the address advances by one after each byte and wraps from 3FFFFh to 00000h. Address bits 23 to 18 are ignored for every command.
- R6: Opcode 05h returns `status_i`, sampled at the start of each output byte, repeatedly for as long as clocks continue. It works while `busy_i` is high.
- R7: Opcode 9Fh returns the repeating sequence 62h, 06h, 12h, 00h.
- R8: Opcode ABh followed by three filler bytes returns 44h repeatedly.
- R9: A framed opcode B9h sets `pd_o` when select rises, unless `busy_i` is high at that moment.
- R10: While `pd_o` is high, every opcode other than ABh is dropped: no output and no strobe. Receiving ABh clears `pd_o`.
- R11: When the pause pin falls while the clock is low and select is low, shifting stops and `so_oe_o` drops. Releasing the pin resumes from the same bit. A select rise cancels the pause.
- R12: `wcmd_valid_o` pulses for one cycle at select rise only if select rises on a byte boundary with the exact byte count: 1 for 06h/04h/C7h, 2 for 01h, 4 for 20h/D7h/D8h, and at least 5 for 02h. `wcmd_op_o` carries the opcode and `wcmd_addr_o` the low 18 address bits.
- R13: Each payload byte after the header of 01h or 02h is forwarded with a one-cycle `wdat_valid_o` pulse on `wdat_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock |
| cs_ni | input | 1 | Active-low select |
| si_i | input | 1 | Serial data in |
| hold_ni | input | 1 | Active-low pause |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for serial data out |
| busy_i | input | 1 | Internal write in progress |
| status_i | input | 8 | Status byte to return |
| mem_rd_o | output | 1 | Array read request |
| mem_addr_o | output | 18 | Array read address |
| mem_data_i | input | 8 | Array data, valid the cycle after a request |
| wcmd_valid_o | output | 1 | Framed write command strobe |
| wcmd_op_o | output | 8 | Opcode of the strobed command |
| wcmd_addr_o | output | 18 | Address of the strobed command |
| wdat_valid_o | output | 1 | Payload byte strobe |
| wdat_o | output | 8 | Payload byte |
| pd_o | output | 1 | Deep-sleep state |

## Verification
The bench reads across the 3FFFFh boundary and with junk in the top address bits. A design that failed to wrap or that kept those bits would return bytes from the wrong location. It truncates commands by a bit or a byte and pads them with extra bytes, so that a framing check that is too loose gives itself away with a spurious strobe. It issues the sleep opcode while busy and then tries other opcodes in sleep, which exposes a design that enters sleep unconditionally or that leaves it on the wrong opcode. It pauses in the middle of an address byte and in the middle of output data, so that a design that kept shifting while paused would return a misaligned byte or keep driving the pin.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  typedef enum logic [2:0] {PH_OPC, PH_ADDR, PH_FILL, PH_OUT, PH_WR, PH_IGN} phase_e;
  typedef enum logic [1:0] {SRC_MEM, SRC_STAT, SRC_ID1, SRC_ID2} src_e;

  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_FREAD = 8'h0B;
  localparam logic [7:0] OP_RSTAT = 8'h05;
  localparam logic [7:0] OP_WSTAT = 8'h01;
  localparam logic [7:0] OP_WLSET = 8'h06;
  localparam logic [7:0] OP_WLCLR = 8'h04;
  localparam logic [7:0] OP_ER4K  = 8'h20;
  localparam logic [7:0] OP_ER4KB = 8'hD7;
  localparam logic [7:0] OP_ER64K = 8'hD8;
  localparam logic [7:0] OP_ERALL = 8'hC7;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_SLEEP = 8'hB9;
  localparam logic [7:0] OP_IDSEQ = 8'h9F;
  localparam logic [7:0] OP_IDWAKE = 8'hAB;
  localparam logic [7:0] ID_SHORT = 8'h44;

  function automatic logic [7:0] id_seq_byte(input logic [1:0] idx);
    case (idx)
      2'd0:    return 8'h62;
      2'd1:    return 8'h06;
      2'd2:    return 8'h12;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
  parameter int          W   = 4,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1 <= RST[i];
        s2 <= RST[i];
      end else begin
        s1 <= d_i[i];
        s2 <= s1;
      end
    end
    assign q_o[i] = s2;
  end
endmodule

// File: rtl/sfe_rx.sv
module sfe_rx
  import sfe_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              cs_fall_i,
  input  logic              cs_rise_i,
  input  logic              si_i,
  input  logic              busy_i,
  input  logic              load_i,
  output phase_e            phase_o,
  output src_e              src_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rd_o,
  output logic              wcmd_valid_o,
  output logic [7:0]        wcmd_op_o,
  output logic [ADDR_W-1:0] wcmd_addr_o,
  output logic              wdat_valid_o,
  output logic [7:0]        wdat_o,
  output logic              pd_o
);
  localparam int          CNT_W    = 3;
  localparam logic [CNT_W-1:0] LAST_ADR = CNT_W'(3);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic [2:0]        bit_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [6:0]        sh_q;
  logic [7:0]        op_q;
  phase_e            phase_q;
  src_e              src_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rd_q, pd_q, take, sleep_go;

  wire       byte_done = rise_i && (bit_q == 3'd7);
  wire [7:0] rx_byte   = {sh_q, si_i};

  always_comb begin
    case (op_q)
      OP_WLSET, OP_WLCLR, OP_ERALL: take = (cnt_q == CNT_W'(1));
      OP_WSTAT:                     take = (cnt_q == CNT_W'(2));
      OP_ER4K, OP_ER4KB, OP_ER64K:  take = (cnt_q == CNT_W'(4));
      OP_PROG:                      take = (cnt_q >= CNT_W'(5));
      default:                      take = 1'b0;
    endcase
    take     = take && (phase_q == PH_WR) && (bit_q == 3'd0);
    sleep_go = (phase_q == PH_WR) && (op_q == OP_SLEEP) && (cnt_q == CNT_W'(1)) &&
               (bit_q == 3'd0) && !busy_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= '0; cnt_q <= '0; sh_q <= '0; op_q <= '0;
      phase_q <= PH_IGN; src_q <= SRC_MEM; addr_q <= '0;
      rd_q <= 1'b0; pd_q <= 1'b0;
      wcmd_valid_o <= 1'b0; wcmd_op_o <= '0; wcmd_addr_o <= '0;
      wdat_valid_o <= 1'b0; wdat_o <= '0;
    end else begin
      rd_q         <= 1'b0;
      wcmd_valid_o <= 1'b0;
      wdat_valid_o <= 1'b0;
      if (cs_fall_i) begin
        bit_q <= '0; cnt_q <= '0; phase_q <= PH_OPC;
      end else if (cs_rise_i) begin
        bit_q <= '0; cnt_q <= '0; phase_q <= PH_IGN;
        wcmd_valid_o <= take;
        wcmd_op_o    <= op_q;
        wcmd_addr_o  <= addr_q;
        if (sleep_go) pd_q <= 1'b1;
      end else begin
        if (rise_i) begin
          sh_q  <= rx_byte[6:0];
          bit_q <= bit_q + 3'd1;
          if (bit_q == 3'd7 && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        end
        if (byte_done) begin
          case (phase_q)
            PH_OPC: begin
              op_q <= rx_byte;
              if (pd_q && rx_byte != OP_IDWAKE) phase_q <= PH_IGN;
              else begin
                if (rx_byte == OP_IDWAKE) pd_q <= 1'b0;
                case (rx_byte)
                  OP_READ, OP_FREAD, OP_IDWAKE, OP_ER4K, OP_ER4KB, OP_ER64K, OP_PROG:
                    phase_q <= PH_ADDR;
                  OP_RSTAT: begin phase_q <= PH_OUT; src_q <= SRC_STAT; end
                  OP_IDSEQ: begin phase_q <= PH_OUT; src_q <= SRC_ID1; end
                  OP_WLSET, OP_WLCLR, OP_ERALL, OP_SLEEP, OP_WSTAT: phase_q <= PH_WR;
                  default: phase_q <= PH_IGN;
                endcase
              end
            end
            PH_ADDR: begin
              addr_q <= {addr_q[ADDR_W-9:0], rx_byte};
              if (cnt_q == LAST_ADR) begin
                case (op_q)
                  OP_READ:   begin phase_q <= PH_OUT; src_q <= SRC_MEM; rd_q <= 1'b1; end
                  OP_FREAD:  phase_q <= PH_FILL;
                  OP_IDWAKE: begin phase_q <= PH_OUT; src_q <= SRC_ID2; end
                  default:   phase_q <= PH_WR;
                endcase
              end
            end
            PH_FILL: begin phase_q <= PH_OUT; src_q <= SRC_MEM; rd_q <= 1'b1; end
            PH_WR: if (op_q == OP_PROG || op_q == OP_WSTAT) begin
              wdat_valid_o <= 1'b1;
              wdat_o       <= rx_byte;
            end
            default: ;
          endcase
        end
        if (load_i && src_q == SRC_MEM) begin
          addr_q <= addr_q + 1'b1;
          rd_q   <= 1'b1;
        end
      end
    end
  end

  assign phase_o = phase_q;
  assign src_o   = src_q;
  assign addr_o  = addr_q;
  assign rd_o    = rd_q;
  assign pd_o    = pd_q;

  AST_WCMD_ON_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wcmd_valid_o |-> $past(bit_q) == 3'd0);  // R12
  AST_WCMD_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wcmd_valid_o |=> !wcmd_valid_o);  // R12
  AST_SLEEP_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pd_q) |-> !$past(busy_i));  // R9
  AST_SLEEP_NO_WCMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_q |-> !wcmd_valid_o);  // R10
endmodule

// File: rtl/sfe_tx.sv
module sfe_tx
  import sfe_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fall_i,
  input  logic       active_i,
  input  logic       cs_edge_i,
  input  logic       cs_rise_i,
  input  logic       hold_i,
  input  src_e       src_i,
  input  logic [7:0] mem_data_i,
  input  logic [7:0] status_i,
  output logic       so_o,
  output logic       oe_o,
  output logic       load_o
);
  logic [2:0] idx_q;
  logic [6:0] sh_q;
  logic       so_q, on_q;
  logic [1:0] id_q;
  logic [7:0] nb;

  always_comb begin
    case (src_i)
      SRC_MEM:  nb = mem_data_i;
      SRC_STAT: nb = status_i;
      SRC_ID1:  nb = id_seq_byte(id_q);
      default:  nb = ID_SHORT;
    endcase
  end

  assign load_o = fall_i && active_i && (idx_q == 3'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0; sh_q <= '0; so_q <= 1'b0; on_q <= 1'b0; id_q <= '0;
    end else if (cs_edge_i) begin
      idx_q <= '0; on_q <= 1'b0; id_q <= '0;
    end else if (fall_i && active_i) begin
      on_q  <= 1'b1;
      idx_q <= idx_q + 3'd1;
      if (idx_q == 3'd0) begin
        {so_q, sh_q} <= nb;
        if (src_i == SRC_ID1) id_q <= id_q + 2'd1;
      end else begin
        so_q <= sh_q[6];
        sh_q <= {sh_q[5:0], 1'b0};
      end
    end
  end

  assign so_o = so_q;
  assign oe_o = on_q && !hold_i;

  AST_FLOAT_AFTER_DESELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise_i |=> !oe_o);  // R2
endmodule

// File: rtl/spi_flash_frontend.sv
module spi_flash_frontend
  import sfe_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              cs_ni,
  input  logic              si_i,
  input  logic              hold_ni,
  output logic              so_o,
  output logic              so_oe_o,
  input  logic              busy_i,
  input  logic [7:0]        status_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_data_i,
  output logic              wcmd_valid_o,
  output logic [7:0]        wcmd_op_o,
  output logic [ADDR_W-1:0] wcmd_addr_o,
  output logic              wdat_valid_o,
  output logic [7:0]        wdat_o,
  output logic              pd_o
);
  localparam int         PINS    = 4;
  localparam logic [PINS-1:0] PIN_RST = 4'b1010;  // {hold, si, cs, sck}

  logic [PINS-1:0] pins_s;
  logic sck_s, cs_s, si_s, hold_s;
  logic sck_d, cs_d, hold_d, hold_act;
  phase_e phase;
  src_e   src;
  logic   load;

  sfe_sync #(.W(PINS), .RST(PIN_RST)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({hold_ni, si_i, cs_ni, sck_i}),
    .q_o (pins_s)
  );
  assign {hold_s, si_s, cs_s, sck_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d <= 1'b0; cs_d <= 1'b1; hold_d <= 1'b1;
    end else begin
      sck_d <= sck_s; cs_d <= cs_s; hold_d <= hold_s;
    end
  end

  wire cs_fall   = cs_d && !cs_s;
  wire cs_rise   = !cs_d && cs_s;
  wire hold_fall = hold_d && !hold_s;
  wire hold_rise = !hold_d && hold_s;
  wire live      = !cs_s && !hold_act;
  wire rise_g    = live && !sck_d && sck_s;
  wire fall_g    = live && sck_d && !sck_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           hold_act <= 1'b0;
    else if (cs_rise || hold_rise)         hold_act <= 1'b0;
    else if (hold_fall && !sck_s && !cs_s) hold_act <= 1'b1;
  end

  sfe_rx #(.ADDR_W(ADDR_W)) u_rx (
    .clk_i, .rst_ni,
    .rise_i      (rise_g),
    .cs_fall_i   (cs_fall),
    .cs_rise_i   (cs_rise),
    .si_i        (si_s),
    .busy_i,
    .load_i      (load),
    .phase_o     (phase),
    .src_o       (src),
    .addr_o      (mem_addr_o),
    .rd_o        (mem_rd_o),
    .wcmd_valid_o, .wcmd_op_o, .wcmd_addr_o,
    .wdat_valid_o, .wdat_o,
    .pd_o
  );

  sfe_tx u_tx (
    .clk_i, .rst_ni,
    .fall_i     (fall_g),
    .active_i   (phase == PH_OUT),
    .cs_edge_i  (cs_fall || cs_rise),
    .cs_rise_i  (cs_rise),
    .hold_i     (hold_act),
    .src_i      (src),
    .mem_data_i,
    .status_i,
    .so_o,
    .oe_o       (so_oe_o),
    .load_o     (load)
  );

  AST_PAUSE_FREEZES_SO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_act && !cs_rise && !cs_fall) |=> $stable(so_o));  // R11
endmodule

// File: tb/spi_flash_frontend_test.sv
module spi_flash_frontend_test;
  localparam int HALF = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, sck, cs_n, si, hold_n, busy;
  logic [7:0] status;
  logic so, so_oe, mem_rd, wcmd_valid, wdat_valid, pd;
  logic [17:0] mem_addr, wcmd_addr;
  logic [7:0]  mem_q, wcmd_op, wdat;

  spi_flash_frontend uut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .si_i(si), .hold_ni(hold_n),
    .so_o(so), .so_oe_o(so_oe), .busy_i(busy), .status_i(status),
    .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_data_i(mem_q),
    .wcmd_valid_o(wcmd_valid), .wcmd_op_o(wcmd_op), .wcmd_addr_o(wcmd_addr),
    .wdat_valid_o(wdat_valid), .wdat_o(wdat), .pd_o(pd)
  );

  function automatic logic [7:0] mem_f(input logic [17:0] a);
    return a[7:0] ^ {a[17:12], a[9:8]} ^ 8'h5A;
  endfunction

  always @(posedge clk) if (mem_rd) mem_q <= mem_f(mem_addr);

  int wc_n = 0, wd_n = 0;
  logic [7:0]  wc_op, wd_last;
  logic [17:0] wc_addr;
  always @(posedge clk) begin
    if (wcmd_valid) begin wc_n <= wc_n + 1; wc_op <= wcmd_op; wc_addr <= wcmd_addr; end
    if (wdat_valid) begin wd_n <= wd_n + 1; wd_last <= wdat; end
  end

  int checks = 0, fails = 0;
  bit oe_seen, oe_miss, done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_lo(input bit m3);
    sck = m3; clks(4); cs_n = 1'b0; clks(HALF);
  endtask

  task automatic cs_hi(input bit m3);
    if (!m3) begin sck = 1'b0; clks(HALF); end
    cs_n = 1'b1; clks(2 * HALF);
  endtask

  task automatic xbit(input logic b, output logic r);
    sck = 1'b0; si = b; clks(HALF);
    r = so;
    if (so_oe) oe_seen = 1'b1; else oe_miss = 1'b1;
    sck = 1'b1; clks(HALF);
  endtask

  task automatic xbyte(input logic [7:0] b, output logic [7:0] r);
    logic t;
    for (int i = 7; i >= 0; i--) begin xbit(b[i], t); r[i] = t; end
  endtask

  task automatic txn(input int n, input logic [47:0] bytes);
    logic [7:0] d;
    cs_lo(1'b0);
    for (int k = 0; k < n; k++) xbyte(bytes[47-8*k -: 8], d);
    cs_hi(1'b0);
  endtask

  // {mode3, filler byte, 24-bit address}
  localparam logic [25:0] VEC [6] = '{
    {1'b0, 1'b0, 24'h000010},
    {1'b1, 1'b0, 24'h012345},
    {1'b0, 1'b1, 24'h03FFFE},
    {1'b1, 1'b1, 24'hFC0100},
    {1'b0, 1'b0, 24'h23FFFF},
    {1'b1, 1'b0, 24'h020000}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, d;
    int n0;
    rst_n = 1'b0; sck = 1'b0; cs_n = 1'b1; si = 1'b0; hold_n = 1'b1;
    busy = 1'b0; status = 8'h00;
    clks(5); rst_n = 1'b1; clks(5);

    chk("R2 reset oe", so_oe, 0);
    chk("R9 reset sleep", pd, 0);
    chk("R12 reset strobe", wcmd_valid, 0);

    // table-driven array reads (R1 R3 R4 R5)
    foreach (VEC[v]) begin
      logic m3, fast;
      logic [23:0] a;
      m3 = VEC[v][25]; fast = VEC[v][24]; a = VEC[v][23:0];
      cs_lo(m3);
      xbyte(fast ? 8'h0B : 8'h03, d);
      xbyte(a[23:16], d); xbyte(a[15:8], d); xbyte(a[7:0], d);
      if (fast) xbyte(8'hFF, d);
      oe_miss = 1'b0;
      for (int i = 0; i < 3; i++) begin
        logic [17:0] ea;
        ea = a[17:0] + 18'(i);
        xbyte(8'h00, r);
        chk(fast ? "R4 R5 R1 fast read" : "R3 R5 R1 read", r, mem_f(ea));
      end
      chk("R2 oe during data", oe_miss, 0);
      cs_hi(m3);
      chk("R2 float after deselect", so_oe, 0);
    end

    // R6 status repeats, live value, while busy
    busy = 1'b1; status = 8'hA5;
    cs_lo(1'b0); xbyte(8'h05, d);
    xbyte(8'h00, r); chk("R6 status 1", r, 8'hA5);
    xbyte(8'h00, r); chk("R6 status 2", r, 8'hA5);
    status = 8'h3C;
    xbyte(8'h00, r); chk("R6 status live", r, 8'h3C);
    cs_hi(1'b0); busy = 1'b0;

    // R7 identification sequence
    cs_lo(1'b1); xbyte(8'h9F, d);
    for (int i = 0; i < 6; i++) begin
      logic [7:0] e;
      case (i % 4) 0: e = 8'h62; 1: e = 8'h06; 2: e = 8'h12; default: e = 8'h00; endcase
      xbyte(8'h00, r); chk("R7 id sequence", r, e);
    end
    cs_hi(1'b1);

    // R8 short identification
    cs_lo(1'b0); xbyte(8'hAB, d); xbyte(8'h00, d); xbyte(8'h00, d); xbyte(8'h00, d);
    xbyte(8'h00, r); chk("R8 short id 1", r, 8'h44);
    xbyte(8'h00, r); chk("R8 short id 2", r, 8'h44);
    cs_hi(1'b0);

    // R12 R13 framing of write commands
    n0 = wc_n; txn(1, {8'h06, 40'h0});
    chk("R12 set-latch strobe", wc_n, n0 + 1); chk("R12 set-latch op", wc_op, 8'h06);
    n0 = wc_n; cs_lo(1'b0); xbyte(8'hC7, d); xbit(1'b1, d[0]); cs_hi(1'b0);
    chk("R12 chip erase off-boundary", wc_n, n0);
    n0 = wc_n; txn(4, {32'h20FABCDE, 16'h0});
    chk("R12 erase strobe", wc_n, n0 + 1); chk("R12 erase op", wc_op, 8'h20);
    chk("R5 R12 erase addr", wc_addr, 18'h2BCDE);
    n0 = wc_n; txn(3, {24'hD80100, 24'h0});
    chk("R12 short erase dropped", wc_n, n0);
    n0 = wd_n; txn(6, 48'h02012345AA55);
    chk("R12 program op", wc_op, 8'h02); chk("R12 program addr", wc_addr, 18'h12345);
    chk("R13 program bytes", wd_n, n0 + 2); chk("R13 last byte", wd_last, 8'h55);
    n0 = wc_n; txn(3, {24'h018C11, 24'h0});
    chk("R12 status write too long", wc_n, n0);
    n0 = wc_n; txn(2, {16'h0184, 32'h0});
    chk("R12 status write strobe", wc_n, n0 + 1); chk("R13 status byte", wd_last, 8'h84);
    n0 = wc_n; txn(2, {16'h0400, 32'h0});
    chk("R12 clear-latch extra byte", wc_n, n0);

    // R9 R10 sleep
    busy = 1'b1; txn(1, {8'hB9, 40'h0});
    chk("R9 sleep ignored while busy", pd, 0);
    busy = 1'b0; txn(1, {8'hB9, 40'h0});
    chk("R9 sleep entered", pd, 1);
    oe_seen = 1'b0;
    cs_lo(1'b0); xbyte(8'h9F, d); xbyte(8'h00, d); cs_hi(1'b0);
    chk("R10 id blocked in sleep", oe_seen, 0);
    n0 = wc_n; txn(1, {8'h06, 40'h0});
    chk("R10 write blocked in sleep", wc_n, n0);
    cs_lo(1'b0); xbyte(8'hAB, d); xbyte(8'h00, d); xbyte(8'h00, d); xbyte(8'h00, d);
    xbyte(8'h00, r); chk("R10 R8 wake id", r, 8'h44);
    cs_hi(1'b0);
    chk("R10 sleep cleared", pd, 0);

    // R11 pause mid-address and mid-data
    cs_lo(1'b0); xbyte(8'h03, d); xbyte(8'h00, d); xbyte(8'h01, d);
    for (int i = 0; i < 4; i++) xbit(1'b0, d[0]);
    sck = 1'b0; clks(HALF); hold_n = 1'b0; clks(HALF);
    si = 1'b1;
    for (int i = 0; i < 3; i++) begin sck = 1'b1; clks(HALF); sck = 1'b0; clks(HALF); end
    hold_n = 1'b1; clks(HALF);
    for (int i = 0; i < 4; i++) xbit(1'b0, d[0]);
    xbyte(8'h00, r); chk("R11 resume after address pause", r, mem_f(18'h00100));
    sck = 1'b0; clks(HALF);
    chk("R11 driving before pause", so_oe, 1);
    r[7] = so;
    hold_n = 1'b0; clks(HALF);
    chk("R11 float while paused", so_oe, 0);
    for (int i = 0; i < 2; i++) begin sck = 1'b1; clks(HALF); sck = 1'b0; clks(HALF); end
    hold_n = 1'b1; clks(HALF);
    chk("R11 drive after release", so_oe, 1);
    sck = 1'b1; clks(HALF);
    for (int i = 6; i >= 0; i--) begin logic t; xbit(1'b0, t); r[i] = t; end
    chk("R11 data intact across pause", r, mem_f(18'h00101));
    hold_n = 1'b0; clks(HALF);
    cs_hi(1'b0); hold_n = 1'b1; clks(HALF);
    cs_lo(1'b0); xbyte(8'h05, d); xbyte(8'h00, r); cs_hi(1'b0);
    chk("R11 deselect clears pause", r, 8'h3C);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule